// File: doc/BRIEF.md
# Programmed-I/O Sector Data Port Engine

This engine sits between an internal byte buffer and the host's data register during programmed-I/O sector transfers. A start strobe opens a transfer. The strobe carries the direction, a byte length, a sectors-per-block setting and, for packet transfers, an initial byte-count limit.

On a read, the host pulls bytes one strobe at a time. On a write, the host pushes bytes into the buffer. The engine keeps the transfer pointer, pulses an interrupt at each block boundary, moves the status code between "data request" (0x58) and "ready" (0x50), and pulses a completion flag when a write has filled the programmed length.

The buffer is an internal RAM. The media side fills it before a read and drains it after a write through a separate byte port. That port is write-and-read and combinational on read.

Top module: `pio_xfer_engine`

## Requirements
- R1: In read mode, while the pointer is below the length, `rd_data` shows the buffer byte at the pointer combinationally, and each `rd_stb` advances the pointer by one.
- R2: A read strobe with the pointer at or past the length sees `rd_data` = 0x00, and the pointer still advances by one.
- R3: `irq` is a one-cycle pulse in the cycle after an accepted strobe, asserted when the new count (pointer+1) is a multiple of max(spd,1)×SECTOR_BYTES, or, for reads, when that strobe took the last byte.
- R4: A read start with a non-zero length sets status 0x58. Status becomes 0x50 in the cycle after the last in-range byte is read. A start with length 0 gives 0x50.
- R5: An accepted write stores `wr_data` at the buffer position of the pointer, which can then be read on the media port. The write that brings the count to the length is followed one cycle later by a `done` pulse, with status 0x50.
- R6: Write strobes after the count has reached the length change neither the pointer nor the buffer.
- R7: After a write start, status reads 0x50. The first `stat_rd` strobe that follows turns it into 0x58 on the next cycle.
- R8: `byte_cnt` loads `start_bc` at start. In packet mode, each in-range read decrements it. When the decrement reaches zero, it reloads with the remaining length (length − pointer − 1), or with 0xF000 when that remainder is 65536 or more. Outside packet mode it holds its loaded value.
- R9: A sectors-per-block setting of 0 behaves as 1.
- R10: `start` resets the pointer to 0 and cancels the transfer in progress. A strobe in the same cycle as `start` has no effect.
- R11: After reset: status 0x50, pointer 0, `byte_cnt` 0, `irq` and `done` low, read mode with length 0.
- R12: A read strobe in write mode returns 0x00 and leaves the pointer unchanged. A write strobe in read mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a new transfer |
| start_write | input | 1 | Direction at start: 1 = host writes into buffer |
| start_pkt | input | 1 | Packet-mode byte-count tracking at start |
| start_len | input | LEN_W | Transfer length in bytes (≤ DEPTH) |
| start_spd | input | 8 | Sectors per interrupt block (0 acts as 1) |
| start_bc | input | 16 | Initial byte-count register value |
| rd_stb | input | 1 | Host data-register read strobe |
| rd_data | output | 8 | Byte presented to the host |
| wr_stb | input | 1 | Host data-register write strobe |
| wr_data | input | 8 | Byte written by the host |
| stat_rd | input | 1 | Host status-register read strobe |
| status | output | 8 | Status code (0x50 ready, 0x58 data request) |
| irq | output | 1 | Interrupt pulse |
| done | output | 1 | Write-in complete pulse |
| byte_cnt | output | 16 | Byte-count register |
| xfer_ptr | output | PTR_W | Transfer pointer |
| mem_we | input | 1 | Media-side buffer write enable |
| mem_addr | input | AW | Media-side buffer address |
| mem_wdata | input | 8 | Media-side write byte |
| mem_rdata | output | 8 | Media-side read byte |

## Verification
The assertions take for granted that `start_len` never exceeds DEPTH and that the host never raises `rd_stb` and `wr_stb` in the same cycle. They also take for granted that the media port writes the buffer only outside an active write-in, because a data-port write wins a collision with it.

The stimulus drives a single kind of strobe per cycle and keeps every length within the buffer. It uses the media port only to fill the buffer before a read and to read back bytes after a write, so every case the assertions rely on stays true.

// File: rtl/pio_xfer_engine.sv
module pio_xfer_engine #(
  parameter int DEPTH = 2048,
  parameter int SECTOR_BYTES = 512,
  parameter int PTR_W = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LEN_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_write,
  input  logic             start_pkt,
  input  logic [LEN_W-1:0] start_len,
  input  logic [7:0]       start_spd,
  input  logic [15:0]      start_bc,
  input  logic             rd_stb,
  output logic [7:0]       rd_data,
  input  logic             wr_stb,
  input  logic [7:0]       wr_data,
  input  logic             stat_rd,
  output logic [7:0]       status,
  output logic             irq,
  output logic             done,
  output logic [15:0]      byte_cnt,
  output logic [PTR_W-1:0] xfer_ptr,
  input  logic             mem_we,
  input  logic [AW-1:0]    mem_addr,
  input  logic [7:0]       mem_wdata,
  output logic [7:0]       mem_rdata
);
  localparam logic [7:0] ST_READY = 8'h50;
  localparam logic [7:0] ST_DRQ   = 8'h58;
  localparam int BLK_W = 9 + $clog2(SECTOR_BYTES);
  localparam int CW = ((PTR_W > LEN_W) ? PTR_W : LEN_W) + 1;

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [LEN_W-1:0] len_q;
  logic [7:0]       spd_q;
  logic             wmode_q, pkt_q, pend_q, irq_q, done_q;
  logic [7:0]       st_q;
  logic [15:0]      bc_q;
  logic [BLK_W-1:0] blk_q;

  wire [CW-1:0] ptr_x = CW'(ptr_q);
  wire [CW-1:0] len_x = CW'(len_q);
  wire [CW-1:0] nxt_x = ptr_x + CW'(1);
  wire in_range = ptr_x < len_x;
  wire at_last  = nxt_x == len_x;

  wire [7:0]       spd_eff = (spd_q == 8'd0) ? 8'd1 : spd_q;
  wire [BLK_W-1:0] blk_len = BLK_W'(spd_eff) * BLK_W'(SECTOR_BYTES);
  wire             blk_end = blk_q == (blk_len - BLK_W'(1));

  wire rd_act = rd_stb & ~wmode_q & ~start;
  wire rd_hit = rd_act & in_range;
  wire wr_act = wr_stb & wmode_q & ~start & in_range;
  wire irq_d  = (rd_hit & (blk_end | at_last)) | (wr_act & blk_end);
  wire done_d = wr_act & at_last;

  wire [CW-1:0] remain    = len_x - nxt_x;
  wire [15:0]   bc_dec    = (bc_q == 16'd0) ? 16'd0 : bc_q - 16'd1;
  wire [15:0]   bc_reload = (remain >= CW'(32'd65536)) ? 16'hF000 : remain[15:0];

  assign rd_data   = (~wmode_q & in_range) ? mem[ptr_q[AW-1:0]] : 8'h00;
  assign mem_rdata = mem[mem_addr];
  assign status    = st_q;
  assign irq       = irq_q;
  assign done      = done_q;
  assign byte_cnt  = bc_q;
  assign xfer_ptr  = ptr_q;

  always_ff @(posedge clk) begin
    if (wr_act)
      mem[ptr_q[AW-1:0]] <= wr_data;
    else if (mem_we)
      mem[mem_addr] <= mem_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      len_q   <= '0;
      spd_q   <= 8'd1;
      wmode_q <= 1'b0;
      pkt_q   <= 1'b0;
      pend_q  <= 1'b0;
      st_q    <= ST_READY;
      bc_q    <= 16'd0;
      blk_q   <= '0;
      irq_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      done_q <= done_d;
      if (start) begin
        ptr_q   <= '0;
        blk_q   <= '0;
        len_q   <= start_len;
        spd_q   <= start_spd;
        wmode_q <= start_write;
        pkt_q   <= start_pkt;
        bc_q    <= start_bc;
        pend_q  <= start_write & (start_len != '0);
        st_q    <= (start_write || start_len == '0) ? ST_READY : ST_DRQ;
      end else begin
        if (rd_act || wr_act)
          ptr_q <= ptr_q + PTR_W'(1);
        if (rd_hit || wr_act)
          blk_q <= blk_end ? '0 : blk_q + BLK_W'(1);
        if (rd_hit && at_last)
          st_q <= ST_READY;
        if (rd_hit && pkt_q)
          bc_q <= (bc_dec == 16'd0) ? bc_reload : bc_dec;
        if (done_d) begin
          st_q   <= ST_READY;
          pend_q <= 1'b0;
        end else if (stat_rd && pend_q) begin
          st_q   <= ST_DRQ;
          pend_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pio_xfer_engine_chk.sv
module pio_xfer_engine_chk #(
  parameter int DEPTH = 2048,
  parameter int PTR_W = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LEN_W = AW + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             start_write,
  input logic [LEN_W-1:0] start_len,
  input logic             rd_stb,
  input logic [7:0]       rd_data,
  input logic             wr_stb,
  input logic [7:0]       status,
  input logic             irq,
  input logic             done,
  input logic [PTR_W-1:0] xfer_ptr
);
  logic             c_w;
  logic [LEN_W-1:0] c_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_w   <= 1'b0;
      c_len <= '0;
    end else if (start) begin
      c_w   <= start_write;
      c_len <= start_len;
    end
  end

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (xfer_ptr == '0) && !irq && !done);

  assert_read_advances_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !c_w && !start) |=> xfer_ptr == PTR_W'($past(xfer_ptr) + PTR_W'(1)));

  assert_past_end_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_w && 32'(xfer_ptr) >= 32'(c_len)) |-> rd_data == 8'h00);

  assert_full_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && c_w && !start && 32'(xfer_ptr) >= 32'(c_len)) |=> $stable(xfer_ptr));

  assert_done_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status == 8'h50);

  assert_done_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_stb));

  assert_irq_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(rd_stb || wr_stb));
endmodule

bind pio_xfer_engine pio_xfer_engine_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_write(start_write),
  .start_len(start_len), .rd_stb(rd_stb), .rd_data(rd_data), .wr_stb(wr_stb),
  .status(status), .irq(irq), .done(done), .xfer_ptr(xfer_ptr)
);

// File: tb/test_pio_xfer_engine.sv
module test_pio_xfer_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int SECT = 16;
  localparam int AW = 8;
  localparam int LW = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, start_write = 0, start_pkt = 0;
  logic [LW-1:0] start_len = '0;
  logic [7:0] start_spd = 8'd1;
  logic [15:0] start_bc = 16'd0;
  logic rd_stb = 0, wr_stb = 0, stat_rd = 0, mem_we = 0;
  logic [7:0] wr_data = 0, mem_wdata = 0;
  logic [AW-1:0] mem_addr = '0;
  logic [7:0] rd_data, status, mem_rdata;
  logic irq, done;
  logic [15:0] byte_cnt, xfer_ptr;

  pio_xfer_engine #(.DEPTH(DEPTH), .SECTOR_BYTES(SECT), .PTR_W(16)) i_pio_xfer_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_write(start_write),
    .start_pkt(start_pkt), .start_len(start_len), .start_spd(start_spd),
    .start_bc(start_bc), .rd_stb(rd_stb), .rd_data(rd_data), .wr_stb(wr_stb),
    .wr_data(wr_data), .stat_rd(stat_rd), .status(status), .irq(irq),
    .done(done), .byte_cnt(byte_cnt), .xfer_ptr(xfer_ptr), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  int irq_seen = 0, done_seen = 0;
  bit cmp_on = 0, mem_cmp = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_ptr, m_len, m_spd, m_bc, m_st;
  bit m_w, m_pkt, m_pend, e_irq, e_done;
  logic [7:0] m_mem [DEPTH];

  always @(posedge clk) begin
    int blk;
    int rem;
    bit acc;
    e_irq = 0;
    e_done = 0;
    acc = 0;
    if (!rst_n) begin
      m_ptr = 0; m_len = 0; m_spd = 1; m_bc = 0; m_st = 'h50;
      m_w = 0; m_pkt = 0; m_pend = 0;
    end else begin
      blk = ((m_spd == 0) ? 1 : m_spd) * SECT;
      if (start) begin
        m_ptr = 0; m_len = start_len; m_spd = start_spd; m_bc = start_bc;
        m_w = start_write; m_pkt = start_pkt;
        m_pend = start_write && (start_len != 0);
        m_st = (start_write || start_len == 0) ? 'h50 : 'h58;
      end else begin
        if (rd_stb && !m_w) begin
          if (m_ptr < m_len) begin
            if (((m_ptr + 1) % blk) == 0 || m_ptr + 1 == m_len) e_irq = 1;
            if (m_ptr + 1 == m_len) m_st = 'h50;
            if (m_pkt) begin
              m_bc = (m_bc == 0) ? 0 : m_bc - 1;
              if (m_bc == 0) begin
                rem = m_len - m_ptr - 1;
                m_bc = (rem >= 65536) ? 'hF000 : rem;
              end
            end
          end
          m_ptr = (m_ptr + 1) % 65536;
        end
        if (wr_stb && m_w && m_ptr < m_len) begin
          acc = 1;
          m_mem[m_ptr] = wr_data;
          m_ptr++;
          if (m_ptr % blk == 0) e_irq = 1;
          if (m_ptr == m_len) begin e_done = 1; m_st = 'h50; m_pend = 0; end
        end
        if (stat_rd && m_pend && !e_done) begin m_st = 'h58; m_pend = 0; end
      end
      if (!acc && mem_we) m_mem[mem_addr] = mem_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && irq) irq_seen++;
    if (rst_n && done) done_seen++;
    if (rst_n && cmp_on) begin
      chk("R4 status", status, m_st);
      chk("R1 pointer", xfer_ptr, m_ptr);
      chk("R8 byte_cnt", byte_cnt, m_bc);
      chk("R3 irq", irq, e_irq);
      chk("R5 done", done, e_done);
      chk("R1 rd_data", rd_data, (!m_w && m_ptr < m_len) ? m_mem[m_ptr] : 0);
      if (mem_cmp) chk("R5 mem_rdata", mem_rdata, m_mem[mem_addr]);
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic go(bit w, bit p, int len, int spd, int bc);
    start = 1; start_write = w; start_pkt = p;
    start_len = LW'(len); start_spd = 8'(spd); start_bc = 16'(bc);
    cyc();
    start = 0;
  endtask

  task automatic rd_n(int n);
    rd_stb = 1;
    repeat (n) cyc();
    rd_stb = 0;
  endtask

  task automatic wr_n(int n, int base);
    for (int i = 0; i < n; i++) begin
      wr_data = 8'(base + i);
      wr_stb = 1;
      cyc();
    end
    wr_stb = 0;
  endtask

  initial begin
    int b0, d0;
    repeat (3) cyc();
    chk("R11 reset status", status, 'h50);
    chk("R11 reset pointer", xfer_ptr, 0);
    chk("R11 reset byte_cnt", byte_cnt, 0);
    chk("R11 reset irq", irq, 0);
    chk("R11 reset done", done, 0);
    chk("R11 reset rd_data", rd_data, 0);
    rst_n = 1;
    cyc();
    cmp_on = 1;
    for (int i = 0; i < DEPTH; i++) begin
      mem_we = 1; mem_addr = AW'(i); mem_wdata = 8'(i) ^ 8'h5A;
      cyc();
    end
    mem_we = 0; mem_addr = '0;
    cyc();
    mem_cmp = 1;

    go(0, 0, 40, 1, 0);
    chk("R1 first byte", rd_data, 'h5A);
    chk("R4 drq after start", status, 'h58);
    b0 = irq_seen;
    rd_n(40); cyc();
    chk("R3 irq count spd1", irq_seen - b0, 3);
    chk("R4 ready after last", status, 'h50);
    chk("R1 pointer after read", xfer_ptr, 40);
    rd_n(2);
    chk("R2 past end data", rd_data, 0);
    chk("R2 past end pointer", xfer_ptr, 42);

    go(0, 0, 70, 2, 0);
    b0 = irq_seen;
    rd_n(70); cyc();
    chk("R3 irq count spd2", irq_seen - b0, 3);

    go(0, 0, 40, 0, 0);
    b0 = irq_seen;
    rd_n(40); cyc();
    chk("R9 irq count spd0", irq_seen - b0, 3);

    go(0, 0, 0, 1, 0);
    chk("R4 zero length ready", status, 'h50);

    go(0, 1, 12, 1, 5);
    rd_n(1);
    chk("R8 decrement", byte_cnt, 4);
    rd_n(4);
    chk("R8 reload remaining", byte_cnt, 7);
    rd_n(7);
    chk("R8 reload at end", byte_cnt, 0);
    go(0, 0, 12, 1, 9);
    rd_n(3);
    chk("R8 hold outside packet", byte_cnt, 9);

    go(1, 0, 20, 1, 0);
    chk("R7 first status", status, 'h50);
    stat_rd = 1; cyc(); stat_rd = 0;
    chk("R7 later status", status, 'h58);
    b0 = irq_seen; d0 = done_seen;
    wr_n(20, 'hA0); cyc();
    chk("R3 write irq count", irq_seen - b0, 1);
    chk("R5 done count", done_seen - d0, 1);
    chk("R5 status after done", status, 'h50);
    wr_n(3, 'hF0);
    chk("R6 pointer held", xfer_ptr, 20);
    mem_addr = 8'd20; cyc();
    chk("R6 buffer untouched", mem_rdata, 20 ^ 'h5A);
    mem_addr = 8'd3; cyc();
    chk("R5 stored byte", mem_rdata, 'hA3);
    chk("R12 read in write mode data", rd_data, 0);
    rd_n(1);
    chk("R12 read in write mode pointer", xfer_ptr, 20);

    go(0, 0, 10, 1, 0);
    wr_n(2, 'hEE);
    chk("R12 write in read mode pointer", xfer_ptr, 0);
    chk("R12 write in read mode buffer", rd_data, 'hA0);

    go(0, 0, 40, 1, 0);
    rd_n(5);
    chk("R10 mid pointer", xfer_ptr, 5);
    start = 1; start_len = LW'(30); rd_stb = 1;
    cyc();
    start = 0; rd_stb = 0;
    chk("R10 restart pointer", xfer_ptr, 0);
    chk("R10 restart status", status, 'h58);
    cyc();
    chk("R10 no irq", irq, 0);

    repeat (3) cyc();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule